// File: doc/BRIEF.md
# Addressed Serial Control Port

This block is the slave end of a three-wire serial bus made of a chip-enable line, a bit clock, a data input and a data output. Every session opens with an 8-bit address. Two addresses load one of two 16-bit control words. A third address starts a read session. In that session the port sends 32-bit status words taken from the head of an adjacent receive FIFO, one after another, for as long as chip enable stays high. The FIFO storage lives outside this block. The port sees only the head entry, a valid flag and a pop strobe.

The bus pins are asynchronous to the port's system clock. Each pin passes through a two-stage synchronizer, and clock edges are detected in the system clock domain. The master may idle the bit clock either high or low. In both cases data is taken on the rising edge and the output moves on the falling edge. A new control word becomes visible only when chip enable falls. The synchronization-reset output combines one control-word bit with an external reset pin. A watchdog flags a chip-enable high time that runs past a parameterised limit.

The FSM has five states:
- `ST_IDLE`: waiting for chip enable.
- `ST_ADDR`: collecting the address byte.
- `ST_LOAD`: collecting control-word data.
- `ST_STREAM`: sending status words.
- `ST_IGNORE`: an unknown address was received, and the rest of the session is skipped.

The transitions are:
- `ST_IDLE` to `ST_ADDR` when chip enable is seen high.
- `ST_ADDR` to `ST_LOAD`, `ST_STREAM` or `ST_IGNORE` on the eighth rising clock edge, depending on the address.
- Every non-idle state back to `ST_IDLE` when chip enable is seen low.

Top module: `serial_ctrl_port`

## Requirements
- R1: The address is taken one bit per rising edge, and the first bit received becomes bit 0 of the address byte (low nibble first, each nibble LSB first). Address 0x6A targets control word 1, 0x6B targets control word 2 and 0x6C starts a read. Any other address leaves both control words unchanged and keeps the data output high for the rest of the session.
- R2: In a write session, the first data bit after the address becomes bit 0 of the control word. The word is copied into the control register only when chip enable falls, and only if at least 16 data bits were received. Bits after the 16th are ignored. A session with fewer than 16 data bits changes nothing.
- R3: Reserved positions are always stored as 0, whatever was sent. With the defaults these are bits 15 and 9 of control word 1 and bits 5 and 4 of control word 2.
- R4: The input is sampled on rising clock edges and the output changes on falling clock edges. Writes and reads give the same result whether the clock idles high or low.
- R5: A word built from a FIFO entry is sent MSB first. Its 32 bits are the preamble 1,0,1,0 followed by the 28-bit entry from bit 27 down to bit 0. The entry fields, from the MSB down, are: offset-found (1), offset code (3), more-data (1), fill level (2), ARI (1), in-sync (1), error code (3), data (16).
- R6: Words follow each other with no gap while chip enable stays high. A word that starts while the FIFO is empty is sent as 32 zeros.
- R7: A FIFO entry is popped with a single-cycle strobe once the falling edge that presents its last bit has occurred. A session that ends earlier leaves the entry at the head, so the next read sends it again. No pop happens for zero words.
- R8: The synchronization-reset output is high while bit 5 of control word 1 is 1 or the external reset pin is high.
- R9: The overrun flag rises once chip enable has been high for CE_LIMIT system clocks. It clears when chip enable falls.
- R10: After reset, the data output is high, the control words hold their initial values (0x0152 and 0x0106), and the overrun flag is low. The data output is high whenever no read session is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_pin | input | 1 | Bus chip enable, asynchronous |
| cl_pin | input | 1 | Bus bit clock, asynchronous |
| di_pin | input | 1 | Bus serial data in, asynchronous |
| do_pin | output | 1 | Bus serial data out, high when idle |
| sync_rst_pin | input | 1 | External synchronization-reset request |
| fifo_entry | input | 28 | Head entry of the receive FIFO |
| fifo_valid | input | 1 | FIFO holds at least one entry |
| fifo_pop | output | 1 | One-cycle pop strobe |
| ctrl_word1 | output | 16 | Control word 1 |
| ctrl_word2 | output | 16 | Control word 2 |
| sync_reset | output | 1 | Combined synchronization reset |
| ce_overrun | output | 1 | Chip enable held high too long |

## Verification
The bench keeps the default word widths, reserved masks and initial values. It sets CE_LIMIT to 3000 clocks, which is long enough for a three-word read session and short enough for one held session to trip the overrun flag. Each bus half-period is eight system clocks, well above the three-sample minimum of the synchronizer. A small FIFO model behind the port shows whether an interrupted read leaves its entry at the head.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam logic [7:0] ADDR_CW1    = 8'h6A;
    localparam logic [7:0] ADDR_CW2    = 8'h6B;
    localparam logic [7:0] ADDR_STREAM = 8'h6C;
    localparam logic [3:0] PREAMBLE    = 4'b1010;
    localparam int         ADDR_BITS   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LOAD,
        ST_STREAM,
        ST_IGNORE
    } state_t;
endpackage

// File: rtl/scp_sync_edge.sv
module scp_sync_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_q,
    output logic [N-1:0] prev_q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta, stab, last;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= 1'b0;
                stab <= 1'b0;
                last <= 1'b0;
            end else begin
                meta <= async_in[i];
                stab <= meta;
                last <= stab;
            end
        end
        assign sync_q[i] = stab;
        assign prev_q[i] = last;
        assign rise[i]   = stab & ~last;
        assign fall[i]   = ~stab & last;
    end
endmodule

// File: rtl/scp_tx_framer.sv
module scp_tx_framer
    import scp_pkg::*;
#(
    parameter int ENTRY_W = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               shift,
    input  logic [ENTRY_W-1:0] entry,
    input  logic               entry_valid,
    output logic               do_bit,
    output logic               pop
);
    localparam int WORD_W = ENTRY_W + 4;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic [WORD_W-1:0] word_sh;
    logic [IDX_W-1:0]  idx;
    logic              word_live;
    logic [WORD_W-1:0] fresh;

    always_comb begin
        fresh = entry_valid ? {PREAMBLE, entry} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_sh   <= '0;
            idx       <= '0;
            word_live <= 1'b0;
            do_bit    <= 1'b1;
            pop       <= 1'b0;
        end else if (!active) begin
            idx       <= '0;
            word_live <= 1'b0;
            do_bit    <= 1'b1;
            pop       <= 1'b0;
        end else begin
            pop <= 1'b0;
            if (shift) begin
                if (idx == '0) begin
                    do_bit    <= fresh[WORD_W-1];
                    word_sh   <= {fresh[WORD_W-2:0], 1'b0};
                    word_live <= entry_valid;
                    idx       <= idx + 1'b1;
                end else begin
                    do_bit  <= word_sh[WORD_W-1];
                    word_sh <= {word_sh[WORD_W-2:0], 1'b0};
                    if (idx == LAST_IDX) begin
                        idx <= '0;
                        pop <= word_live;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/scp_ce_watchdog.sv
module scp_ce_watchdog #(
    parameter int LIMIT = 86640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_high,
    output logic overrun
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] TRIP = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            overrun <= 1'b0;
        end else if (!ce_high) begin
            cnt     <= '0;
            overrun <= 1'b0;
        end else if (cnt == TRIP) begin
            overrun <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
    import scp_pkg::*;
#(
    parameter int            CW_W       = 16,
    parameter int            ENTRY_W    = 28,
    parameter int            CE_LIMIT   = 86640,
    parameter int            SYR_BIT    = 5,
    parameter logic [CW_W-1:0] RSVD1_MASK = 16'h8200,
    parameter logic [CW_W-1:0] RSVD2_MASK = 16'h0030,
    parameter logic [CW_W-1:0] CW1_INIT   = 16'h0152,
    parameter logic [CW_W-1:0] CW2_INIT   = 16'h0106
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_pin,
    input  logic               cl_pin,
    input  logic               di_pin,
    output logic               do_pin,
    input  logic               sync_rst_pin,
    input  logic [ENTRY_W-1:0] fifo_entry,
    input  logic               fifo_valid,
    output logic               fifo_pop,
    output logic [CW_W-1:0]    ctrl_word1,
    output logic [CW_W-1:0]    ctrl_word2,
    output logic               sync_reset,
    output logic               ce_overrun
);
    localparam int DC_W  = $clog2(CW_W + 1);
    localparam int DI_W  = $clog2(CW_W);
    localparam int AC_W  = $clog2(ADDR_BITS);
    localparam logic [AC_W-1:0] ADDR_LAST = AC_W'(ADDR_BITS - 1);

    logic [2:0] pin_q, pin_prev, pin_rise, pin_fall;
    logic ce_q, ce_prev, ce_fall, di_q, cl_rise, cl_fall;

    scp_sync_edge #(.N(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({di_pin, cl_pin, ce_pin}),
        .sync_q   (pin_q),
        .prev_q   (pin_prev),
        .rise     (pin_rise),
        .fall     (pin_fall)
    );

    assign ce_q    = pin_q[0];
    assign ce_prev = pin_prev[0];
    assign ce_fall = pin_fall[0];
    assign cl_rise = pin_rise[1];
    assign cl_fall = pin_fall[1];
    assign di_q    = pin_q[2];

    state_t state, state_next;
    logic [ADDR_BITS-2:0] addr_sh;
    logic [AC_W-1:0]      bit_cnt;
    logic [CW_W-1:0]      data_sh;
    logic [DC_W-1:0]      dcnt;
    logic                 to_cw2;
    logic [7:0]           addr_full;

    assign addr_full = {di_q, addr_sh};

    always_comb begin
        state_next = state;
        unique case (state)
            ST_IDLE: begin
                if (ce_q) state_next = ST_ADDR;
            end
            ST_ADDR: begin
                if (!ce_q) begin
                    state_next = ST_IDLE;
                end else if (cl_rise && bit_cnt == ADDR_LAST) begin
                    if (addr_full == ADDR_CW1 || addr_full == ADDR_CW2)
                        state_next = ST_LOAD;
                    else if (addr_full == ADDR_STREAM)
                        state_next = ST_STREAM;
                    else
                        state_next = ST_IGNORE;
                end
            end
            ST_LOAD, ST_STREAM, ST_IGNORE: begin
                if (!ce_q) state_next = ST_IDLE;
            end
            default: state_next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_sh    <= '0;
            bit_cnt    <= '0;
            data_sh    <= '0;
            dcnt       <= '0;
            to_cw2     <= 1'b0;
            ctrl_word1 <= CW1_INIT & ~RSVD1_MASK;
            ctrl_word2 <= CW2_INIT & ~RSVD2_MASK;
        end else begin
            if (state == ST_IDLE) begin
                bit_cnt <= '0;
                dcnt    <= '0;
            end
            if (state == ST_ADDR && cl_rise) begin
                if (bit_cnt != ADDR_LAST) addr_sh[bit_cnt] <= di_q;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_ADDR && state_next == ST_LOAD) begin
                to_cw2 <= (addr_full == ADDR_CW2);
            end
            if (state == ST_LOAD && cl_rise && dcnt < DC_W'(CW_W)) begin
                data_sh[dcnt[DI_W-1:0]] <= di_q;
                dcnt <= dcnt + 1'b1;
            end
            if (state == ST_LOAD && ce_fall && dcnt == DC_W'(CW_W)) begin
                if (to_cw2) ctrl_word2 <= data_sh & ~RSVD2_MASK;
                else        ctrl_word1 <= data_sh & ~RSVD1_MASK;
            end
        end
    end

    scp_tx_framer #(.ENTRY_W(ENTRY_W)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (state_next == ST_STREAM),
        .shift       (cl_fall),
        .entry       (fifo_entry),
        .entry_valid (fifo_valid),
        .do_bit      (do_pin),
        .pop         (fifo_pop)
    );

    scp_ce_watchdog #(.LIMIT(CE_LIMIT)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_high (ce_q),
        .overrun (ce_overrun)
    );

    assign sync_reset = ctrl_word1[SYR_BIT] | sync_rst_pin;
endmodule

// File: rtl/scp_checker.sv
module scp_checker
    import scp_pkg::*;
#(
    parameter int              CW_W  = 16,
    parameter logic [CW_W-1:0] RSVD1 = '0,
    parameter logic [CW_W-1:0] RSVD2 = '0
) (
    input logic            clk,
    input logic            rst_n,
    input state_t          state,
    input logic            ce_q,
    input logic            ce_prev,
    input logic            do_pin,
    input logic            fifo_pop,
    input logic            fifo_valid,
    input logic [CW_W-1:0] cw1,
    input logic [CW_W-1:0] cw2,
    input logic            overrun
);
    // R2
    cw1_commit_on_ce_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cw1) |-> ($past(ce_prev) && !$past(ce_q)));

    // R2
    cw2_commit_on_ce_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cw2) |-> ($past(ce_prev) && !$past(ce_q)));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cw1 & RSVD1) == '0) && ((cw2 & RSVD2) == '0));

    // R7
    pop_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_valid);

    // R7
    pop_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R9
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_q |=> !overrun);

    // R10
    idle_do_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> do_pin);
endmodule

bind serial_ctrl_port scp_checker #(
    .CW_W  (CW_W),
    .RSVD1 (RSVD1_MASK),
    .RSVD2 (RSVD2_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .ce_q       (ce_q),
    .ce_prev    (ce_prev),
    .do_pin     (do_pin),
    .fifo_pop   (fifo_pop),
    .fifo_valid (fifo_valid),
    .cw1        (ctrl_word1),
    .cw2        (ctrl_word2),
    .overrun    (ce_overrun)
);

// File: tb/serial_ctrl_port_tb.sv
module serial_ctrl_port_tb;
    localparam int PH    = 8;
    localparam int LIMIT = 3000;
    localparam logic [15:0] M1 = 16'h8200;
    localparam logic [15:0] M2 = 16'h0030;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce = 1'b0, cl = 1'b0, di = 1'b0, ext_rst = 1'b0;
    logic do_pin, fifo_pop, sync_reset, ce_overrun;
    logic fifo_valid = 1'b0;
    logic [27:0] fifo_entry = '0;
    logic [15:0] cw1, cw2;
    int checks = 0, errors = 0;
    logic [27:0] mq[$];
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;

    serial_ctrl_port #(.CE_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_pin(ce), .cl_pin(cl), .di_pin(di),
        .do_pin(do_pin), .sync_rst_pin(ext_rst), .fifo_entry(fifo_entry),
        .fifo_valid(fifo_valid), .fifo_pop(fifo_pop), .ctrl_word1(cw1),
        .ctrl_word2(cw2), .sync_reset(sync_reset), .ce_overrun(ce_overrun)
    );

    // FIFO model behind the port
    always @(posedge clk) if (fifo_pop && mq.size() > 0) void'(mq.pop_front());
    always @(negedge clk) begin
        fifo_valid = (mq.size() > 0);
        fifo_entry = (mq.size() > 0) ? mq[0] : 28'h0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_s(input bit hi);
        cl = hi; wait_clk(6); ce = 1'b1; wait_clk(6);
    endtask

    task automatic end_s(input bit hi);
        if (!hi) cl = 1'b0;
        wait_clk(6); ce = 1'b0; cl = hi; wait_clk(10);
    endtask

    task automatic xfer(input bit b, output bit o);
        cl = 1'b0; di = b; wait_clk(PH); o = do_pin; cl = 1'b1; wait_clk(PH);
    endtask

    task automatic send_addr(input logic [7:0] a, output bit all_high);
        bit o;
        all_high = 1'b1;
        for (int i = 0; i < 8; i++) begin
            xfer(a[i], o);
            all_high &= o;
        end
    endtask

    task automatic write_cw(input logic [7:0] a, input logic [15:0] v, input int n,
                            input bit hi, input bit stay);
        bit o, ah;
        begin_s(hi);
        send_addr(a, ah);
        for (int i = 0; i < n; i++) xfer((i < 16) ? v[i] : 1'b1, o);
        if (!stay) end_s(hi);
    endtask

    // driver: push expected words, then shift out and let the monitor compare
    task automatic read_words(input bit hi, input int nbits, input string req);
        bit o, ah;
        logic [31:0] w = '0;
        for (int k = 0; k < nbits / 32; k++)
            exp_q.push_back(k < mq.size() ? {4'b1010, mq[k]} : 32'h0);
        begin_s(hi);
        send_addr(8'h6C, ah);
        for (int i = 0; i < nbits; i++) begin
            xfer(1'b0, o);
            w = {w[30:0], o};
            if (i % 32 == 31) monitor_word(w, req);
        end
        end_s(hi);
    endtask

    task automatic monitor_word(input logic [31:0] got, input string req);
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(req, got, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ah, o;
        wait_clk(5); rst_n = 1'b1; wait_clk(5);
        // R10 reset state
        chk("R10 do idle", {31'h0, do_pin}, 32'h1);
        chk("R10 cw1 init", {16'h0, cw1}, 32'h0152);
        chk("R10 cw2 init", {16'h0, cw2}, 32'h0106);
        chk("R9 overrun low", {31'h0, ce_overrun}, 32'h0);
        chk("R8 sync reset low", {31'h0, sync_reset}, 32'h0);

        // R2: not visible before chip enable falls
        write_cw(8'h6A, 16'hA35C, 16, 1'b0, 1'b1);
        chk("R2 held until ce fall", {16'h0, cw1}, 32'h0152);
        end_s(1'b0);
        chk("R3 cw1 reserved cleared", {16'h0, cw1}, {16'h0, 16'hA35C & ~M1});

        // R4 idle-high clock, R1 address 0x6B
        write_cw(8'h6B, 16'h7E39, 16, 1'b1, 1'b0);
        chk("R4 cw2 idle-high write", {16'h0, cw2}, {16'h0, 16'h7E39 & ~M2});
        chk("R1 cw1 untouched by 6B", {16'h0, cw1}, 32'h215C);

        // R2 short session discarded, long session truncated
        write_cw(8'h6A, 16'h0000, 10, 1'b0, 1'b0);
        chk("R2 short write ignored", {16'h0, cw1}, 32'h215C);
        write_cw(8'h6B, 16'h1234, 20, 1'b0, 1'b0);
        chk("R2 extra bits ignored", {16'h0, cw2}, 32'h1204);

        // R1 unknown address
        begin_s(1'b0);
        send_addr(8'h6D, ah);
        ah = 1'b1;
        for (int i = 0; i < 16; i++) begin xfer(1'b1, o); ah &= o; end
        end_s(1'b0);
        chk("R1 unknown addr do high", {31'h0, ah}, 32'h1);
        chk("R1 unknown addr cw1", {16'h0, cw1}, 32'h215C);
        chk("R1 unknown addr cw2", {16'h0, cw2}, 32'h1204);

        // R8 sync reset sources
        write_cw(8'h6A, 16'h0020, 16, 1'b0, 1'b0);
        chk("R8 sync reset from word", {31'h0, sync_reset}, 32'h1);
        write_cw(8'h6A, 16'h0000, 16, 1'b0, 1'b0);
        chk("R8 sync reset cleared", {31'h0, sync_reset}, 32'h0);
        ext_rst = 1'b1; wait_clk(1);
        chk("R8 sync reset from pin", {31'h0, sync_reset}, 32'h1);
        ext_rst = 1'b0; wait_clk(1);

        // R5 R6 streaming, empty tail
        mq.push_back(28'h9A5C3E1);
        mq.push_back(28'h4C30F0F);
        wait_clk(2);
        read_words(1'b0, 96, "R5 R6 stream word");
        chk("R7 both entries popped", mq.size(), 32'd0);

        // R4 read with idle-high clock
        mq.push_back(28'hFEDCBA9);
        wait_clk(2);
        read_words(1'b1, 32, "R4 idle-high read");
        chk("R7 popped after idle-high read", mq.size(), 32'd0);

        // R7 interrupted read keeps the entry
        mq.push_back(28'h0123456);
        mq.push_back(28'h7654321);
        wait_clk(2);
        read_words(1'b0, 20, "R7 partial");
        chk("R7 partial read keeps entry", mq.size(), 32'd2);
        read_words(1'b0, 32, "R7 reread head");
        chk("R7 one entry left", mq.size(), 32'd1);
        read_words(1'b1, 64, "R6 then zeros");
        chk("R7 no pop on zero word", mq.size(), 32'd0);

        // R9 watchdog
        cl = 1'b0; ce = 1'b1;
        wait_clk(LIMIT - 100);
        chk("R9 below limit", {31'h0, ce_overrun}, 32'h0);
        wait_clk(200);
        chk("R9 overrun raised", {31'h0, ce_overrun}, 32'h1);
        ce = 1'b0; wait_clk(10);
        chk("R9 overrun cleared", {31'h0, ce_overrun}, 32'h0);
        chk("R10 do high after sessions", {31'h0, do_pin}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule